// File: doc/BRIEF.md
# Three-Input Word Combiner with Shift and Edge Masks

This block is the per-word datapath of a rectangular raster engine. For each accepted word slot it takes one 16-bit word from each of three source streams (A, B, C) and produces one destination word D. Stream A is clipped by edge masks and stream B is not. Both A and B then pass through independent barrel shifters. Bits that leave one word enter the next word of the same row. The three operands are combined bit by bit through an 8-bit programmable truth table, so any Boolean function of three inputs can be selected by one control byte.

The addressing and fetch sequencer in front of the block marks each word as first-of-row and/or last-of-row. It also says which channels are fetched and which run backwards through memory. A channel that is not fetched takes its operand from a held preload value. The result is registered, so D appears one cycle after the word is presented.

Top module: `raster_combine`

## Requirements
- R1: Each bit i of the result equals `truth[{a_i, b_i, c_i}]`, where a_i, b_i and c_i are bit i of the prepared A, B and C operands and A is the most significant index bit. Index 7 means all three bits are one, and index 0 means all three are zero. C is never shifted or masked.
- R2: The truth codes give these functions: 0xCA gives (A AND B) OR (NOT A AND C), 0xF0 gives A, 0xCC gives B, 0xAA gives C, 0x00 gives all zeros, 0xFF gives all ones, 0x5A gives A XOR C and 0x3C gives A XOR B.
- R3: When `desc_mode`=0, A is shifted toward bit 0 by `a_shift` (0 to 15). The vacated high bits are filled from the low bits of the previous A word of the same row.
- R4: B has its own shifter, driven by `b_shift`, which behaves like A's and is independent of it.
- R5: On a word with `row_first`=1, the shift carry of A and of B is zero, whatever earlier rows held.
- R6: On a word with `row_first`=1, A is ANDed with `first_mask`. On a word with `row_last`=1, A is ANDed with `last_mask`. A word with both flags set is ANDed with both masks.
- R7: Masking comes before shifting. The value carried into the next word is the masked A word.
- R8: When `use_a`, `use_b` or `use_c` is 0, that channel's operand is `a_hold`, `b_hold` or `c_hold` instead of the streamed word.
- R9: When `desc_mode`=1, A and B are shifted toward bit 15. The vacated low bits are filled from the high bits of the previously processed word of the same row.
- R10: `out_valid` is `in_valid` delayed by one cycle. `d_word` takes the result one cycle after an accepted word and holds its value while no word is accepted.
- R11: In reset, `out_valid` and `d_word` are zero and both shift carries are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word slot is presented this cycle |
| row_first | input | 1 | Word is the first of its row |
| row_last | input | 1 | Word is the last of its row |
| desc_mode | input | 1 | Row is processed in the descending direction |
| use_a | input | 1 | A operand comes from the stream (else from the hold value) |
| use_b | input | 1 | B operand comes from the stream |
| use_c | input | 1 | C operand comes from the stream |
| a_word | input | 16 | Streamed A word |
| b_word | input | 16 | Streamed B word |
| c_word | input | 16 | Streamed C word |
| a_hold | input | 16 | Preload value for A |
| b_hold | input | 16 | Preload value for B |
| c_hold | input | 16 | Preload value for C |
| a_shift | input | 4 | Shift amount for A |
| b_shift | input | 4 | Shift amount for B |
| first_mask | input | 16 | Mask ANDed into A on the first word of a row |
| last_mask | input | 16 | Mask ANDed into A on the last word of a row |
| truth | input | 8 | Truth table of the combining function |
| out_valid | output | 1 | `d_word` carries a fresh result |
| d_word | output | 16 | Destination word |

## Verification
Several functions can act on one A word in the same cycle. On a one-word row, both edge masks apply together with the carry clear of the shifter. On a row's opening word, the first-word mask is combined with a non-zero shift, and the masked bits must not come back in the next word. The bench provokes these cases with one-word rows and with two-word shifted rows whose first mask cuts the bits that would otherwise be carried. Each result is judged against an expected word that the bench builds bit by bit from the masks, the shift direction and the truth table. Rows of different directions and shift amounts are run back to back, so that a stale carry leaking across a row boundary would show in the output.

// File: rtl/rcomb_pkg.sv
package rcomb_pkg;
    // three sources feed the truth table
    localparam int N_SRC = 3;
    localparam int TT_W  = 1 << N_SRC;

    typedef struct packed {
        logic first;
        logic last;
        logic desc;
    } word_pos_t;

    function automatic logic tt_pick(input logic [TT_W-1:0] tt,
                                     input logic a, input logic b, input logic c);
        return tt[{a, b, c}];
    endfunction
endpackage

// File: rtl/edge_mask.sv
module edge_mask #(
    parameter int W = 16
) (
    input  logic [W-1:0] word_in,
    input  logic         at_first,
    input  logic         at_last,
    input  logic [W-1:0] lead_mask,
    input  logic [W-1:0] tail_mask,
    output logic [W-1:0] word_out
);
    logic [W-1:0] lead_eff;
    logic [W-1:0] tail_eff;

    always_comb begin
        lead_eff = at_first ? lead_mask : '1;
        tail_eff = at_last  ? tail_mask : '1;
        word_out = word_in & lead_eff & tail_eff;
    end
endmodule

// File: rtl/lane_shift.sv
module lane_shift #(
    parameter int W  = 16,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          row_start,
    input  logic          desc,
    input  logic [SW-1:0] amount,
    input  logic [W-1:0]  cur,
    output logic [W-1:0]  shifted
);
    logic [W-1:0] carry_q;
    logic [W-1:0] carry_eff;

    always_comb begin
        carry_eff = row_start ? '0 : carry_q;
        if (desc)
            shifted = W'(({cur, carry_eff} << amount) >> W);
        else
            shifted = W'({carry_eff, cur} >> amount);
    end

    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= '0;
        else if (adv)
            carry_q <= cur;
    end
endmodule

// File: rtl/minterm_unit.sv
module minterm_unit
    import rcomb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [W-1:0]    op_c,
    input  logic [TT_W-1:0] tt,
    output logic [W-1:0]    res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i] = tt_pick(tt, op_a[i], op_b[i], op_c[i]);
    end
endmodule

// File: rtl/raster_combine.sv
module raster_combine
    import rcomb_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SHIFT_W = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               row_first,
    input  logic               row_last,
    input  logic               desc_mode,
    input  logic               use_a,
    input  logic               use_b,
    input  logic               use_c,
    input  logic [WORD_W-1:0]  a_word,
    input  logic [WORD_W-1:0]  b_word,
    input  logic [WORD_W-1:0]  c_word,
    input  logic [WORD_W-1:0]  a_hold,
    input  logic [WORD_W-1:0]  b_hold,
    input  logic [WORD_W-1:0]  c_hold,
    input  logic [SHIFT_W-1:0] a_shift,
    input  logic [SHIFT_W-1:0] b_shift,
    input  logic [WORD_W-1:0]  first_mask,
    input  logic [WORD_W-1:0]  last_mask,
    input  logic [TT_W-1:0]    truth,
    output logic               out_valid,
    output logic [WORD_W-1:0]  d_word
);
    word_pos_t          pos;
    logic [WORD_W-1:0]  a_src, b_src, c_src;
    logic [WORD_W-1:0]  a_clip;
    logic [WORD_W-1:0]  a_aligned, b_aligned;
    logic [WORD_W-1:0]  d_next;

    // operand select: streamed word or held preload (R8)
    always_comb begin
        pos   = '{first: row_first, last: row_last, desc: desc_mode};
        a_src = use_a ? a_word : a_hold;
        b_src = use_b ? b_word : b_hold;
        c_src = use_c ? c_word : c_hold;
    end

    // edge clipping on A only, ahead of the shifter (R6, R7)
    edge_mask #(.W(WORD_W)) u_amask (
        .word_in  (a_src),
        .at_first (pos.first),
        .at_last  (pos.last),
        .lead_mask(first_mask),
        .tail_mask(last_mask),
        .word_out (a_clip)
    );

    // cross-word alignment (R3, R4, R5, R9)
    lane_shift #(.W(WORD_W), .SW(SHIFT_W)) u_ashift (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .row_start(pos.first),
        .desc     (pos.desc),
        .amount   (a_shift),
        .cur      (a_clip),
        .shifted  (a_aligned)
    );

    lane_shift #(.W(WORD_W), .SW(SHIFT_W)) u_bshift (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .row_start(pos.first),
        .desc     (pos.desc),
        .amount   (b_shift),
        .cur      (b_src),
        .shifted  (b_aligned)
    );

    // bitwise truth-table evaluation (R1, R2)
    minterm_unit #(.W(WORD_W)) u_logic (
        .op_a(a_aligned),
        .op_b(b_aligned),
        .op_c(c_src),
        .tt  (truth),
        .res (d_next)
    );

    // output register (R10, R11)
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            d_word    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                d_word <= d_next;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(d_word)));

    // R2
    clear_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && truth == 8'h00) |=> (d_word == '0));

    // R2
    set_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && truth == 8'hFF) |=> (d_word == '1));

    // R1
    c_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && truth == 8'hAA) |=> (d_word == $past(c_src)));

    // R8
    hold_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_c && truth == 8'hAA) |=> (d_word == $past(c_hold)));
endmodule

// File: tb/raster_combine_tb.sv
module raster_combine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    typedef struct packed {
        logic        first;
        logic        last;
        logic        desc;
        logic        ua;
        logic        ub;
        logic        uc;
        logic [3:0]  ash;
        logic [3:0]  bsh;
        logic [7:0]  tt;
        logic [15:0] fm;
        logic [15:0] lm;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd4, 4'd0, 8'hCA,16'hFFFF,16'hFFFF,16'hF0F0,16'h1234,16'hABCD},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'd4, 4'd0, 8'hCA,16'hFFFF,16'hFFFF,16'h0F0F,16'h5678,16'h1111},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'd4, 4'd0, 8'hCA,16'hFFFF,16'h0000,16'hFFFF,16'h9ABC,16'h2222},
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'd0, 4'd7, 8'hCC,16'h00FF,16'h0FF0,16'h1234,16'h8001,16'h0000},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'd3, 4'd5, 8'h5A,16'h7FFF,16'hFFFF,16'h8421,16'hF00F,16'h0F0F},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'd3, 4'd5, 8'h5A,16'h7FFF,16'hFFFE,16'h1248,16'h0000,16'hFFFF},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2, 4'd2, 8'hCA,16'hFFFF,16'hFFFF,16'h0000,16'h0000,16'h0000},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd15,4'd15,8'h3C,16'hFFFF,16'hFFFF,16'hFFFF,16'h0001,16'h0000},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'd15,4'd15,8'h3C,16'hFFFF,16'hFFFF,16'h0000,16'h8000,16'h0000},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd0, 4'd0, 8'hAA,16'hFFFF,16'hFFFF,16'h0001,16'h0002,16'hBEEF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, row_first, row_last, desc_mode;
    logic        use_a, use_b, use_c;
    logic [15:0] a_word, b_word, c_word;
    logic [15:0] a_hold, b_hold, c_hold;
    logic [3:0]  a_shift, b_shift;
    logic [15:0] first_mask, last_mask;
    logic [7:0]  truth;
    logic        out_valid;
    logic [15:0] d_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side carry memory of the reference computation
    logic [15:0] m_ca, m_cb;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_combine u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .row_first(row_first), .row_last(row_last), .desc_mode(desc_mode),
        .use_a(use_a), .use_b(use_b), .use_c(use_c),
        .a_word(a_word), .b_word(b_word), .c_word(c_word),
        .a_hold(a_hold), .b_hold(b_hold), .c_hold(c_hold),
        .a_shift(a_shift), .b_shift(b_shift),
        .first_mask(first_mask), .last_mask(last_mask),
        .truth(truth), .out_valid(out_valid), .d_word(d_word)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] align(input logic [15:0] cur, input logic [15:0] prev,
                                          input logic dsc, input int sh);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            if (!dsc) r[i] = (i + sh < 16) ? cur[i + sh] : prev[i + sh - 16];
            else      r[i] = (i >= sh) ? cur[i - sh] : prev[16 + i - sh];
        end
        return r;
    endfunction

    task automatic model(input vec_t v, output logic [15:0] exp);
        logic [15:0] sa, sb, sc, pa, pb, ra, rb;
        sa = v.ua ? v.a : a_hold;
        sb = v.ub ? v.b : b_hold;
        sc = v.uc ? v.c : c_hold;
        if (v.first) sa = sa & v.fm;
        if (v.last)  sa = sa & v.lm;
        pa = v.first ? 16'h0000 : m_ca;
        pb = v.first ? 16'h0000 : m_cb;
        ra = align(sa, pa, v.desc, int'(v.ash));
        rb = align(sb, pb, v.desc, int'(v.bsh));
        for (int i = 0; i < 16; i++)
            exp[i] = v.tt[{ra[i], rb[i], sc[i]}];
        m_ca = sa;
        m_cb = sb;
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        row_first = v.first; row_last = v.last; desc_mode = v.desc;
        use_a = v.ua; use_b = v.ub; use_c = v.uc;
        a_shift = v.ash; b_shift = v.bsh; truth = v.tt;
        first_mask = v.fm; last_mask = v.lm;
        a_word = v.a; b_word = v.b; c_word = v.c;
    endtask

    // drive at negedge, capture at posedge, sample at the next negedge
    task automatic step(input vec_t v, input string req, input logic [15:0] exp);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, d_word, exp);
        check({req, " valid"}, {15'd0, out_valid}, 16'h0001);
    endtask

    function automatic vec_t mk(input logic f, input logic l, input logic d,
                                input logic [3:0] ash, input logic [7:0] tt,
                                input logic [15:0] fm, input logic [15:0] lm,
                                input logic [15:0] a, input logic [15:0] b,
                                input logic [15:0] c);
        vec_t v;
        v = '{first: f, last: l, desc: d, ua: 1'b1, ub: 1'b1, uc: 1'b1,
              ash: ash, bsh: 4'd0, tt: tt, fm: fm, lm: lm, a: a, b: b, c: c};
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] e;
        vec_t v;
        rst = 1'b1; in_valid = 1'b0; row_first = 1'b0; row_last = 1'b0;
        desc_mode = 1'b0; use_a = 1'b1; use_b = 1'b1; use_c = 1'b1;
        a_word = '0; b_word = '0; c_word = '0;
        a_hold = 16'hF00F; b_hold = 16'h0FF0; c_hold = 16'h5555;
        a_shift = '0; b_shift = '0; first_mask = '1; last_mask = '1; truth = '0;
        m_ca = '0; m_cb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 reset d_word", d_word, 16'h0000);
        check("R11 reset out_valid", {15'd0, out_valid}, 16'h0000);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R5 R6 R8 R9 against the bench reference
        for (int i = 0; i < NV; i++) begin
            model(VEC[i], e);
            step(VEC[i], $sformatf("R1 vector %0d", i), e);
        end

        // R2 cookie-cut by hand
        step(mk(1,1,0,4'd0,8'hCA,16'hFFFF,16'hFFFF,16'hFF00,16'h1234,16'hABCD), "R2 cookie", 16'h12CD);
        // R2 xor A,C
        step(mk(1,1,0,4'd0,8'h5A,16'hFFFF,16'hFFFF,16'h0FF0,16'h0,16'hFF00), "R2 xor", 16'hF0F0);
        // R3 ascending carry across words
        step(mk(1,0,0,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'h8001,16'h0,16'h0), "R3 first word", 16'h0800);
        step(mk(0,1,0,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'h0000,16'h0,16'h0), "R3 carry word", 16'h1000);
        // R5 new row after a carry-leaving word: no leak
        step(mk(1,0,0,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'hFFFF,16'h0,16'h0), "R5 prime", 16'h0FFF);
        step(mk(1,1,0,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'h0000,16'h0,16'h0), "R5 clear", 16'h0000);
        // R6 single-word row: both masks
        step(mk(1,1,0,4'd0,8'hF0,16'h0FF0,16'h3C3C,16'hFFFF,16'h0,16'h0), "R6 both masks", 16'h0C30);
        // R7 mask before shift
        step(mk(1,0,0,4'd8,8'hF0,16'h00FF,16'hFFFF,16'hFFFF,16'h0,16'h0), "R7 first", 16'h0000);
        step(mk(0,1,0,4'd8,8'hF0,16'hFFFF,16'hFFFF,16'h0000,16'h0,16'h0), "R7 carried", 16'hFF00);
        // R9 descending
        step(mk(1,0,1,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'h8001,16'h0,16'h0), "R9 first", 16'h0010);
        step(mk(0,1,1,4'd4,8'hF0,16'hFFFF,16'hFFFF,16'h0000,16'h0,16'h0), "R9 carry", 16'h0008);
        // R4 B shifter independent of A
        v = mk(1,1,0,4'd0,8'hCC,16'hFFFF,16'hFFFF,16'hFFFF,16'hF000,16'h0);
        v.bsh = 4'd8;
        step(v, "R4 b shift", 16'h00F0);
        // R8 A preload
        v = mk(1,1,0,4'd0,8'hF0,16'hFFFF,16'hFFFF,16'h1111,16'h0,16'h0);
        v.ua = 1'b0;
        step(v, "R8 a preload", 16'hF00F);

        // R10 idle cycle: out_valid low and d_word held
        @(posedge clk);
        @(negedge clk);
        check("R10 idle valid", {15'd0, out_valid}, 16'h0000);
        check("R10 idle hold", d_word, 16'hF00F);

        // R11 reset clears carries: prime, reset, then non-first word
        step(mk(1,0,0,4'd8,8'hF0,16'hFFFF,16'hFFFF,16'hFFFF,16'h0,16'h0), "R11 prime", 16'h00FF);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(mk(0,1,0,4'd8,8'hF0,16'hFFFF,16'hFFFF,16'h0000,16'h0,16'h0), "R11 carry cleared", 16'h0000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule